// File: doc/BRIEF.md
# Tuning-Window Phase Selector

This block picks the receive sampling phase of a high-speed card interface. On a start request it asks for the delay line to be reset. It then steps through all 16 sampling phases in ascending order. For each phase it asks for that phase to be programmed, asks for one tuning transfer, and records whether the transfer passed. The pass results go into a 16-bit mask.

After the sweep the block treats the passing phases as circular runs. A run that reaches phase 15 continues with a run that starts at phase 0. The block keeps the longest run and takes the entry three quarters of the way into it. It then asks for that phase to be programmed and reports it.

If no phase passed, the whole sequence, reset included, is repeated, up to a fixed number of attempts. After the last attempt the block reports failure. Tuning is skipped when the bus clock is at or below a threshold, or when the timing mode is not one of the tuned modes. In that case the block reports completion at once with a bypass flag.

Top module: `phase_sweep_tuner`

## Requirements
- R1: After reset, done_o, err_o, bypass_o, dll_init_req_o, prog_req_o and xfer_req_o are 0 and sel_phase_o is 0.
- R2: A start with bus_mhz_i <= 100, or with mode_i other than 3 or 5, raises no request. done_o pulses on the cycle after start. It pulses with bypass_o=1, err_o=0 and sel_phase_o=0.
- R3: A tuned start raises dll_init_req_o once per attempt. The sweep then programs phases 0,1,...,15 in order. Each prog_req_o is acknowledged before one xfer_req_o follows, and prog_phase_o holds while its request is pending.
- R4: Passing phases split into windows wherever two passing phases are not adjacent. The longest window is chosen, and on equal lengths the one whose first phase is lowest is kept.
- R5: When phases 15 and 0 both pass and not all phases pass, the window ending at 15 and the window starting at 0 form one window. The 15 side comes first, and the merged window is ranked by its start on the 15 side.
- R6: For a chosen window of length L, the entry index is q=floor(3L/4), decremented by one when q is nonzero. The selected phase is (window start + index) mod 16.
- R7: If no phase passes, the attempt repeats from the delay-line reset, for at most 3 attempts. After the third empty sweep, done_o pulses with err_o=1 and sel_phase_o=0, and no final programming is requested.
- R8: On success, the selected phase is programmed through prog_req_o as the last request. done_o then pulses with err_o=0, bypass_o=0 and sel_phase_o equal to that phase.
- R9: At most one of the three request outputs is high in any cycle, and done_o is high for exactly one cycle per start.
- R10: When all 16 phases pass, the selected phase is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tuning run (taken while idle) |
| bus_mhz_i | input | 10 | Bus clock frequency in MHz |
| mode_i | input | 3 | Timing mode code |
| dll_init_req_o | output | 1 | Request delay-line reset |
| dll_init_ack_i | input | 1 | Delay-line reset finished |
| prog_req_o | output | 1 | Request programming of prog_phase_o |
| prog_phase_o | output | 4 | Phase to program |
| prog_ack_i | input | 1 | Phase programmed |
| xfer_req_o | output | 1 | Request one tuning transfer |
| xfer_ack_i | input | 1 | Transfer finished, xfer_pass_i valid |
| xfer_pass_i | input | 1 | Transfer result, 1 = pass |
| done_o | output | 1 | One-cycle completion pulse |
| sel_phase_o | output | 4 | Selected phase |
| err_o | output | 1 | No passing phase after all attempts |
| bypass_o | output | 1 | Run completed without tuning |

## Verification
The assertions take two things for granted. Every acknowledge is a one-cycle pulse given only while its own request is high. bus_mhz_i and mode_i are stable while a run is in progress. The bench responders meet both. Each waits at the falling edge for a raised request, delays a random zero to two cycles, and pulses the matching acknowledge for one cycle. Frequency and mode change only between runs. Pass results come from per-attempt masks that the bench fixes before start. The masks are a directed set covering wrap, tie, single-phase, all-pass and empty sweeps, plus masks drawn from a fixed-seed $urandom.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_PROG, ST_XFER, ST_CHECK,
    ST_SCAN, ST_PICK, ST_FINAL, ST_DONE
  } tune_st_e;
endpackage

// File: rtl/tune_gate.sv
module tune_gate #(
  parameter int MHZ_W = 10,
  parameter int MIN_MHZ = 100,
  parameter int MODE_W = 3,
  parameter int NMODE = 2,
  parameter logic [NMODE*MODE_W-1:0] TUNED_MODES = {3'd5, 3'd3}
) (
  input  logic [MHZ_W-1:0]  mhz_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              skip_o
);
  logic [NMODE-1:0] hit;
  for (genvar i = 0; i < NMODE; i++) begin : g_mode
    assign hit[i] = (mode_i == TUNED_MODES[i*MODE_W +: MODE_W]);
  end
  assign skip_o = (mhz_i <= MHZ_W'(MIN_MHZ)) || (hit == '0);
endmodule

// File: rtl/tune_run_scan.sv
module tune_run_scan #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic [NPH-1:0] mask_i,
  output logic [PW-1:0]  best_start_o,
  output logic [LW-1:0]  best_len_o
);
  logic [PW:0]   k_q;
  logic          trk_q;
  logic [PW-1:0] cur_start_q;
  logic [LW-1:0] cur_len_q;
  logic [PW-1:0] p, prv;
  logic          hit_p, hit_prv;

  assign p       = k_q[PW-1:0];
  assign prv     = p - 1'b1;
  assign hit_p   = mask_i[p];
  assign hit_prv = mask_i[prv];

  // Two laps: starts are taken on the first lap only, so runs wrapping past the top finish on the second.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0; trk_q <= 1'b0; cur_start_q <= '0; cur_len_q <= '0;
      best_start_o <= '0; best_len_o <= '0;
    end else if (clr_i) begin
      k_q <= '0; trk_q <= 1'b0; cur_start_q <= '0; cur_len_q <= '0;
      best_start_o <= '0; best_len_o <= '0;
    end else if (step_i) begin
      k_q <= k_q + 1'b1;
      if (hit_p && !hit_prv) begin
        if (!k_q[PW]) begin
          trk_q       <= 1'b1;
          cur_start_q <= p;
          cur_len_q   <= LW'(1);
        end else begin
          trk_q <= 1'b0;
        end
      end else if (hit_p && trk_q) begin
        cur_len_q <= cur_len_q + 1'b1;
      end else if (!hit_p && trk_q) begin
        trk_q <= 1'b0;
        if (cur_len_q > best_len_o) begin
          best_len_o   <= cur_len_q;
          best_start_o <= cur_start_q;
        end
      end
    end
  end
endmodule

// File: rtl/tune_pick.sv
module tune_pick #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1
) (
  input  logic [PW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  output logic [PW-1:0] phase_o
);
  logic [LW+1:0] tri_len, q, idx;
  always_comb begin
    tri_len = {len_i, 1'b0} + (LW+2)'(len_i);
    q       = tri_len >> 2;
    idx     = (q != '0) ? q - 1'b1 : q;
    phase_o = start_i + idx[PW-1:0];
  end
endmodule

// File: rtl/phase_sweep_tuner.sv
module phase_sweep_tuner
  import phase_tune_pkg::*;
#(
  parameter int NPH = 16,
  parameter int MAX_TRIES = 3,
  parameter int MHZ_W = 10,
  parameter int MIN_MHZ = 100,
  parameter int MODE_W = 3,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MHZ_W-1:0]  bus_mhz_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              dll_init_req_o,
  input  logic              dll_init_ack_i,
  output logic              prog_req_o,
  output logic [PW-1:0]     prog_phase_o,
  input  logic              prog_ack_i,
  output logic              xfer_req_o,
  input  logic              xfer_ack_i,
  input  logic              xfer_pass_i,
  output logic              done_o,
  output logic [PW-1:0]     sel_phase_o,
  output logic              err_o,
  output logic              bypass_o
);
  tune_st_e      st_q;
  logic [PW-1:0] ph_q;
  logic [NPH-1:0] mask_q;
  logic [TW-1:0] tries_q;
  logic [PW:0]   scan_q;
  logic          skip;
  logic          full;
  logic [PW-1:0] run_start, pick_start, pick_ph;
  logic [LW-1:0] run_len, pick_len;

  tune_gate #(.MHZ_W(MHZ_W), .MIN_MHZ(MIN_MHZ), .MODE_W(MODE_W)) u_gate (
    .mhz_i(bus_mhz_i), .mode_i(mode_i), .skip_o(skip));

  tune_run_scan #(.NPH(NPH)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(st_q == ST_CHECK), .step_i(st_q == ST_SCAN),
    .mask_i(mask_q), .best_start_o(run_start), .best_len_o(run_len));

  assign full       = &mask_q;
  assign pick_start = full ? '0 : run_start;
  assign pick_len   = full ? LW'(NPH) : run_len;

  tune_pick #(.NPH(NPH)) u_pick (
    .start_i(pick_start), .len_i(pick_len), .phase_o(pick_ph));

  assign dll_init_req_o = (st_q == ST_INIT);
  assign prog_req_o     = (st_q == ST_PROG) || (st_q == ST_FINAL);
  assign prog_phase_o   = (st_q == ST_FINAL) ? sel_phase_o : ph_q;
  assign xfer_req_o     = (st_q == ST_XFER);
  assign done_o         = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= '0; mask_q <= '0; tries_q <= '0; scan_q <= '0;
      sel_phase_o <= '0; err_o <= 1'b0; bypass_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sel_phase_o <= '0;
          err_o       <= 1'b0;
          bypass_o    <= skip;
          tries_q     <= '0;
          st_q        <= skip ? ST_DONE : ST_INIT;
        end
        ST_INIT: if (dll_init_ack_i) begin
          ph_q   <= '0;
          mask_q <= '0;
          st_q   <= ST_PROG;
        end
        ST_PROG: if (prog_ack_i) st_q <= ST_XFER;
        ST_XFER: if (xfer_ack_i) begin
          mask_q[ph_q] <= xfer_pass_i;
          if (ph_q == PW'(NPH - 1)) begin
            st_q <= ST_CHECK;
          end else begin
            ph_q <= ph_q + 1'b1;
            st_q <= ST_PROG;
          end
        end
        ST_CHECK: begin
          scan_q <= '0;
          if (mask_q == '0) begin
            if (tries_q == TW'(MAX_TRIES - 1)) begin
              err_o <= 1'b1;
              st_q  <= ST_DONE;
            end else begin
              tries_q <= tries_q + 1'b1;
              st_q    <= ST_INIT;
            end
          end else begin
            st_q <= full ? ST_PICK : ST_SCAN;
          end
        end
        ST_SCAN: begin
          scan_q <= scan_q + 1'b1;
          if (scan_q == (PW+1)'(2*NPH - 1)) st_q <= ST_PICK;
        end
        ST_PICK: begin
          sel_phase_o <= pick_ph;
          st_q        <= ST_FINAL;
        end
        ST_FINAL: if (prog_ack_i) st_q <= ST_DONE;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_sweep_tuner_chk.sv
module phase_sweep_tuner_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dll_init_req_o,
  input logic       prog_req_o,
  input logic [3:0] prog_phase_o,
  input logic       prog_ack_i,
  input logic       xfer_req_o,
  input logic       done_o,
  input logic [3:0] sel_phase_o,
  input logic       err_o,
  input logic       bypass_o
);
  assert_one_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dll_init_req_o, prog_req_o, xfer_req_o}));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !prog_ack_i) |=> (prog_req_o && $stable(prog_phase_o)));

  assert_xfer_after_prog_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_req_o) |-> $past(prog_ack_i));

  assert_bypass_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bypass_o) |-> (!err_o && sel_phase_o == 4'd0));

  assert_fail_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (sel_phase_o == 4'd0 && !bypass_o));
endmodule

bind phase_sweep_tuner phase_sweep_tuner_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dll_init_req_o(dll_init_req_o),
  .prog_req_o(prog_req_o), .prog_phase_o(prog_phase_o), .prog_ack_i(prog_ack_i),
  .xfer_req_o(xfer_req_o), .done_o(done_o), .sel_phase_o(sel_phase_o),
  .err_o(err_o), .bypass_o(bypass_o));

// File: tb/phase_sweep_tuner_test.sv
module phase_sweep_tuner_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] bus_mhz_i = 10'd200;
  logic [2:0] mode_i = 3'd3;
  logic       dll_init_ack_i = 1'b0, prog_ack_i = 1'b0, xfer_ack_i = 1'b0, xfer_pass_i = 1'b0;
  logic       dll_init_req_o, prog_req_o, xfer_req_o, done_o, err_o, bypass_o;
  logic [3:0] prog_phase_o, sel_phase_o;

  int n_chk = 0, n_bad = 0;
  int n_init = 0, n_prog = 0, n_xfer = 0, n_done = 0;
  int prog_log [0:63];
  logic [3:0] last_ph = 4'd0;
  logic [15:0] amask [0:2];

  always #2 clk_i = ~clk_i;

  phase_sweep_tuner uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk_i);
    if (dll_init_req_o) begin
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
      n_init++; dll_init_ack_i = 1'b1;
      @(negedge clk_i); dll_init_ack_i = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (prog_req_o) begin
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
      if (n_prog < 64) prog_log[n_prog] = int'(prog_phase_o);
      n_prog++; last_ph = prog_phase_o; prog_ack_i = 1'b1;
      @(negedge clk_i); prog_ack_i = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (xfer_req_o) begin
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
      n_xfer++;
      xfer_pass_i = amask[(n_init > 0 && n_init <= 3) ? n_init - 1 : 0][last_ph];
      xfer_ack_i = 1'b1;
      @(negedge clk_i); xfer_ack_i = 1'b0; xfer_pass_i = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (done_o) n_done++;
  end

  // List-based model: ascending rows, wrap merge, first longest row, 3/4 entry.
  function automatic int exp_phase(input logic [15:0] m);
    int rs [0:15];
    int rl [0:15];
    int nr = 0, lastp = -2, best = 0, bl = 0, q;
    for (int p = 0; p < 16; p++) begin
      if (m[p]) begin
        if (nr == 0 || lastp + 1 != p) begin rs[nr] = p; rl[nr] = 0; nr++; end
        rl[nr-1]++; lastp = p;
      end
    end
    if (nr > 1 && rs[0] == 0 && rs[nr-1] + rl[nr-1] - 1 == 15) begin
      rl[nr-1] += rl[0]; rl[0] = 0;
    end
    for (int r = 0; r < nr; r++) if (rl[r] > bl) begin bl = rl[r]; best = r; end
    q = (bl * 3) / 4;
    if (q != 0) q--;
    return (rs[best] + q) % 16;
  endfunction

  task automatic run_case(input int mhz, input int mode, input logic [15:0] m0,
                          input logic [15:0] m1, input logic [15:0] m2, input string tag);
    int tries, expsel, t0, timeout;
    bit ok, seq_ok, byp;
    amask[0] = m0; amask[1] = m1; amask[2] = m2;
    bus_mhz_i = 10'(mhz); mode_i = 3'(mode);
    n_init = 0; n_prog = 0; n_xfer = 0; n_done = 0;
    byp = (mhz <= 100) || !(mode == 3 || mode == 5);
    tries = (m0 != 0) ? 1 : (m1 != 0) ? 2 : 3;
    ok = !byp && (tries < 3 || m2 != 0);
    expsel = ok ? exp_phase(amask[tries-1]) : 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    t0 = 0; timeout = 0;
    while (!done_o) begin
      @(negedge clk_i); t0++;
      if (t0 > 5000) begin timeout = 1; break; end
    end
    chk(!timeout, {tag, " R9 done seen"}, timeout, 0);
    if (byp) begin
      chk(t0 == 0, {tag, " R2 done latency"}, t0, 0);
      chk(bypass_o && !err_o && sel_phase_o == 0 && n_init == 0 && n_prog == 0 && n_xfer == 0,
          {tag, " R2 bypass"}, int'(bypass_o) + n_init + n_prog, 1);
    end else begin
      chk(n_init == tries && n_xfer == 16 * tries, {tag, " R3 R7 attempts"}, n_init, tries);
      seq_ok = (n_prog == 16 * tries + (ok ? 1 : 0));
      for (int i = 0; i < 16 * tries && i < 64; i++) if (prog_log[i] != i % 16) seq_ok = 0;
      chk(seq_ok, {tag, " R3 sweep order"}, n_prog, 16 * tries + (ok ? 1 : 0));
      if (ok) begin
        chk(sel_phase_o == 4'(expsel) && !err_o && !bypass_o, {tag, " R4 R5 R6 R8 selection"},
            int'(sel_phase_o), expsel);
        chk(prog_log[n_prog-1] == expsel, {tag, " R8 final program"}, prog_log[n_prog-1], expsel);
      end else begin
        chk(err_o && sel_phase_o == 0 && !bypass_o, {tag, " R7 failure flag"}, int'(err_o), 1);
      end
    end
    repeat (3) @(negedge clk_i);
    chk(n_done == 1, {tag, " R9 single done"}, n_done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    amask[0] = 16'h0; amask[1] = 16'h0; amask[2] = 16'h0;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !err_o && !bypass_o && !dll_init_req_o && !prog_req_o && !xfer_req_o
        && sel_phase_o == 0, "R1 reset outputs", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!dll_init_req_o && !prog_req_o && !xfer_req_o && !done_o, "R1 idle", int'(prog_req_o), 0);

    run_case(100, 3, 16'hFFFF, 0, 0, "clk at limit");
    run_case(200, 1, 16'hFFFF, 0, 0, "untuned mode");
    run_case(101, 5, 16'hFFFF, 0, 0, "R10 all pass");
    run_case(200, 3, 16'h0001, 0, 0, "only phase 0");
    run_case(200, 3, 16'h8000, 0, 0, "only phase 15");
    run_case(200, 5, 16'hE003, 0, 0, "R5 wrap merge");
    run_case(200, 3, 16'h0E1C, 0, 0, "R4 tie earliest");
    run_case(200, 3, 16'h7FFE, 0, 0, "R6 len 14");
    run_case(200, 3, 16'h8001, 0, 0, "R5 wrap pair");
    run_case(200, 3, 16'h0, 16'h0F00, 0, "R7 second try");
    run_case(200, 5, 16'h0, 16'h0, 16'h0030, "R7 third try");
    run_case(200, 3, 16'h0, 16'h0, 16'h0, "R7 all fail");
    for (int n = 0; n < 40; n++) begin
      logic [15:0] rm;
      rm = 16'($urandom);
      if (n % 4 == 0) rm = rm | 16'h8001;
      run_case(150, (n % 2 == 0) ? 3 : 5, rm, 16'($urandom) | 16'h1, 16'h1, "random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule